// File: doc/BRIEF.md
# I2C Bus Timing Solver

This block works out the contents of a 32-bit I2C bus timing word for a controller whose kernel clock period is known. A caller presents the kernel clock period in whole nanoseconds and a speed grade (standard, fast or fast-plus), pulses a start strobe, and some cycles later receives the packed timing word together with a one-cycle done strobe and an error flag.

The solver runs in two passes. In the first pass it walks every prescaler value. For each one it finds the smallest setup-delay count and the smallest hold-delay count that meet the grade's limits, and records that triple. In the second pass it revisits each recorded prescaler and sweeps the SCL low and high counts. It keeps the combination whose full bus period comes closest to the grade's nominal period. Each candidate takes one clock cycle, and the products are formed by running additions. Both sweeps stop early once a larger count can no longer give a better result.

Top module: `i2c_timing_solver`

## Requirements
- R1: Grade encoding on `grade_i`: 0 selects standard, 1 selects fast and 2 selects fast-plus. The limits in ns (low min, high min, rise, fall, setup min, data valid max, period min, period max, target period) are: standard 4700, 4000, 640, 20, 250, 3450, 8333, 12500, 10000; fast 1300, 600, 250, 100, 100, 900, 2083, 3125, 2500; fast-plus 500, 260, 60, 100, 50, 450, 833, 1250, 1000.
- R2: Pass one. Let tP = (P+1)·t for each prescaler P in 0..15, where t is the kernel clock period. The setup count is the smallest S in 0..15 with (S+1)·tP ≥ rise + setup min. The hold count is the smallest H in 0..15 with H·tP ≥ max(0, fall − 50 − 3t) and H·tP ≤ max(0, valid max − rise − 260 − 4t). A prescaler is recorded only when both counts exist.
- R3: Pass two. The low time is 50 + 2t + (L+1)·tP and must exceed low min with t < floor((low − 50)/4). The high time is 50 + 2t + (Hc+1)·tP and must be at least high min and greater than t. L and Hc each range over 0..255.
- R4: The period is low + high + rise + fall and must lie within [period min, period max]. The chosen candidate minimises |period − target period|. A candidate replaces the current best only if its error is strictly smaller, so on ties the earlier candidate is kept (prescaler ascending, then L, then Hc).
- R5: Word layout: bits 31:28 prescaler, 27:24 zero, 23:20 setup count, 19:16 hold count, 15:8 high count Hc, 7:0 low count L.
- R6: When no candidate qualifies, the word is 0 and the error flag is 1. The same result follows when the period is 0 or the grade is 3. On success the error flag is 0.
- R7: `done_o` pulses for exactly one cycle per accepted start. A start that arrives while a search is running is ignored and does not change its result.
- R8: After reset the word, done and error outputs are 0. The word and error outputs change only in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| tclk_ns_i | input | 16 | Kernel clock period in ns |
| grade_i | input | 2 | Speed grade select |
| word_o | output | 32 | Packed timing word |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | No valid timing found |

## Verification
The search is exercised on all three grades across several clock periods. Short periods make the small prescalers fail the setup test, so the solver has to pick a later table entry. Long periods push the hold window down to zero, and a slow kernel clock on fast-plus makes every candidate fail the period window, which separates the error path from a legitimate result. A zero period, the unused grade code and a second start during a running search check the rejection paths. Each result is compared against an exhaustive reference sweep that does no early termination, so a wrong pruning bound or a wrong tie rule shows up as a differing word.

// File: rtl/i2cts_pkg.sv
package i2cts_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCL,
        S_SDA,
        S_LOAD,
        S_LOW,
        S_HIGH,
        S_FINISH
    } solve_state_e;

    typedef struct packed {
        logic [15:0] low_min;
        logic [15:0] high_min;
        logic [15:0] rise;
        logic [15:0] fall;
        logic [15:0] setup_min;
        logic [15:0] valid_max;
        logic [15:0] per_min;
        logic [15:0] per_max;
        logic [15:0] per_target;
    } grade_limits_t;

endpackage

// File: rtl/i2cts_limits.sv
module i2cts_limits
    import i2cts_pkg::*;
(
    input  logic [1:0]    grade_i,
    output grade_limits_t lim_o
);
    always_comb begin
        case (grade_i)
            2'd0:    lim_o = '{16'd4700, 16'd4000, 16'd640, 16'd20,  16'd250,
                               16'd3450, 16'd8333, 16'd12500, 16'd10000};
            2'd1:    lim_o = '{16'd1300, 16'd600,  16'd250, 16'd100, 16'd100,
                               16'd900,  16'd2083, 16'd3125,  16'd2500};
            default: lim_o = '{16'd500,  16'd260,  16'd60,  16'd100, 16'd50,
                               16'd450,  16'd833,  16'd1250,  16'd1000};
        endcase
    end
endmodule

// File: rtl/i2cts_cand_table.sv
module i2cts_cand_table #(
    parameter int ENTRIES = 16,
    parameter int PW      = 4,
    parameter int DW      = 4,
    parameter int ACC_W   = 32
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [PW-1:0]    waddr_i,
    input  logic [PW-1:0]    wpresc_i,
    input  logic [DW-1:0]    wscl_i,
    input  logic [DW-1:0]    wsda_i,
    input  logic [ACC_W-1:0] wtp_i,
    input  logic [PW-1:0]    raddr_i,
    output logic [PW-1:0]    rpresc_o,
    output logic [DW-1:0]    rscl_o,
    output logic [DW-1:0]    rsda_o,
    output logic [ACC_W-1:0] rtp_o
);
    typedef struct packed {
        logic [PW-1:0]    presc;
        logic [DW-1:0]    scl;
        logic [DW-1:0]    sda;
        logic [ACC_W-1:0] tp;
    } entry_t;

    entry_t slot_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we_i && (waddr_i == PW'(g))) begin
                slot_q[g] <= '{wpresc_i, wscl_i, wsda_i, wtp_i};
            end
        end
    end

    assign rpresc_o = slot_q[raddr_i].presc;
    assign rscl_o   = slot_q[raddr_i].scl;
    assign rsda_o   = slot_q[raddr_i].sda;
    assign rtp_o    = slot_q[raddr_i].tp;
endmodule

// File: rtl/i2c_timing_solver.sv
module i2c_timing_solver
    import i2cts_pkg::*;
#(
    parameter int TCLK_W  = 16,
    parameter int ACC_W   = 32,
    parameter int PRESC_N = 16,
    parameter int DEL_N   = 16,
    parameter int CNT_N   = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TCLK_W-1:0] tclk_ns_i,
    input  logic [1:0]        grade_i,
    output logic [31:0]       word_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int PW = $clog2(PRESC_N);
    localparam int DW = $clog2(DEL_N);
    localparam int CW = $clog2(CNT_N);
    localparam int IW = $clog2(PRESC_N + 1);
    localparam logic [PW-1:0] PRESC_LAST = PW'(PRESC_N - 1);
    localparam logic [DW-1:0] DEL_LAST   = DW'(DEL_N - 1);
    localparam logic [CW-1:0] CNT_LAST   = CW'(CNT_N - 1);

    typedef struct packed {
        solve_state_e      st;
        logic [TCLK_W-1:0] tclk;
        logic [1:0]        grade;
        logic [PW-1:0]     presc;
        logic [DW-1:0]     scldel;
        logic [DW-1:0]     sdadel;
        logic [ACC_W-1:0]  tp;
        logic [ACC_W-1:0]  acc;
        logic [ACC_W-1:0]  tlow;
        logic [ACC_W-1:0]  thigh;
        logic [ACC_W-1:0]  best_err;
        logic [IW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic [CW-1:0]     scll;
        logic [CW-1:0]     sclh;
        logic              found;
        logic [31:0]       best;
        logic [31:0]       word;
        logic              err;
        logic              done;
    } solve_regs_t;

    solve_regs_t q, d;
    grade_limits_t lim;

    logic             tab_we;
    logic [PW-1:0]    rd_presc;
    logic [DW-1:0]    rd_scl;
    logic [DW-1:0]    rd_sda;
    logic [ACC_W-1:0] rd_tp;

    i2cts_limits u_limits (
        .grade_i (q.grade),
        .lim_o   (lim)
    );

    i2cts_cand_table #(
        .ENTRIES (PRESC_N),
        .PW      (PW),
        .DW      (DW),
        .ACC_W   (ACC_W)
    ) u_table (
        .clk      (clk),
        .we_i     (tab_we),
        .waddr_i  (q.cnt[PW-1:0]),
        .wpresc_i (q.presc),
        .wscl_i   (q.scldel),
        .wsda_i   (q.sdadel),
        .wtp_i    (q.tp),
        .raddr_i  (q.idx[PW-1:0]),
        .rpresc_o (rd_presc),
        .rscl_o   (rd_scl),
        .rsda_o   (rd_sda),
        .rtp_o    (rd_tp)
    );

    // derived timing quantities, all in ns
    logic [ACC_W-1:0] t_w, rf, setup_need, hbase, sda_min, sda_max;
    logic [ACC_W-1:0] min_sub, max_sub, t0, tscl, tscl_err, target;
    logic             low_ok, nb_low, nb_high, high_ok;

    function automatic logic beyond(input logic [ACC_W-1:0] per,
                                    input logic [ACC_W-1:0] tgt,
                                    input logic [ACC_W-1:0] pmax,
                                    input logic [ACC_W-1:0] berr);
        return (per > pmax) || ((per >= tgt) && ((per - tgt) >= berr));
    endfunction

    always_comb begin
        t_w        = ACC_W'(q.tclk);
        rf         = ACC_W'(lim.rise) + ACC_W'(lim.fall);
        target     = ACC_W'(lim.per_target);
        setup_need = ACC_W'(lim.rise) + ACC_W'(lim.setup_min);
        hbase      = ACC_W'(50) + (t_w << 1);
        min_sub    = ACC_W'(50) + t_w + (t_w << 1);
        max_sub    = ACC_W'(lim.rise) + ACC_W'(260) + (t_w << 2);
        sda_min    = (ACC_W'(lim.fall) > min_sub) ? ACC_W'(lim.fall) - min_sub : '0;
        sda_max    = (ACC_W'(lim.valid_max) > max_sub) ? ACC_W'(lim.valid_max) - max_sub : '0;
        low_ok     = (q.tlow > ACC_W'(lim.low_min)) &&
                     (q.tlow >= (t_w << 2) + ACC_W'(54));
        t0         = q.tlow + hbase + q.tp + rf;
        nb_low     = beyond(t0, target, ACC_W'(lim.per_max), q.best_err);
        tscl       = q.tlow + q.thigh + rf;
        nb_high    = beyond(tscl, target, ACC_W'(lim.per_max), q.best_err);
        tscl_err   = (tscl >= target) ? tscl - target : target - tscl;
        high_ok    = (tscl >= ACC_W'(lim.per_min)) &&
                     (q.thigh >= ACC_W'(lim.high_min)) && (q.thigh > t_w);
    end

    always_comb begin
        logic adv_presc;
        logic adv_scll;
        d         = q;
        d.done    = 1'b0;
        tab_we    = 1'b0;
        adv_presc = 1'b0;
        adv_scll  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.tclk  = tclk_ns_i;
                    d.grade = grade_i;
                    d.found = 1'b0;
                    if ((tclk_ns_i == '0) || (grade_i == 2'd3)) begin
                        d.st = S_FINISH;
                    end else begin
                        d.presc  = '0;
                        d.scldel = '0;
                        d.tp     = ACC_W'(tclk_ns_i);
                        d.acc    = ACC_W'(tclk_ns_i);
                        d.cnt    = '0;
                        d.st     = S_SCL;
                    end
                end
            end
            S_SCL: begin
                if (q.acc >= setup_need) begin
                    d.sdadel = '0;
                    d.acc    = '0;
                    d.st     = S_SDA;
                end else if (q.scldel == DEL_LAST) begin
                    adv_presc = 1'b1;
                end else begin
                    d.scldel = q.scldel + 1'b1;
                    d.acc    = q.acc + q.tp;
                end
            end
            S_SDA: begin
                if ((q.acc >= sda_min) && (q.acc <= sda_max)) begin
                    tab_we    = 1'b1;
                    d.cnt     = q.cnt + 1'b1;
                    adv_presc = 1'b1;
                end else if (q.sdadel == DEL_LAST) begin
                    adv_presc = 1'b1;
                end else begin
                    d.sdadel = q.sdadel + 1'b1;
                    d.acc    = q.acc + q.tp;
                end
            end
            S_LOAD: begin
                if (q.idx == q.cnt) begin
                    d.st = S_FINISH;
                end else begin
                    d.presc  = rd_presc;
                    d.scldel = rd_scl;
                    d.sdadel = rd_sda;
                    d.tp     = rd_tp;
                    d.scll   = '0;
                    d.tlow   = hbase + rd_tp;
                    d.st     = S_LOW;
                end
            end
            S_LOW: begin
                if (nb_low) begin
                    d.idx = q.idx + 1'b1;
                    d.st  = S_LOAD;
                end else if (low_ok) begin
                    d.sclh  = '0;
                    d.thigh = hbase + q.tp;
                    d.st    = S_HIGH;
                end else begin
                    adv_scll = 1'b1;
                end
            end
            S_HIGH: begin
                if (nb_high) begin
                    adv_scll = 1'b1;
                end else begin
                    if (high_ok && (tscl_err < q.best_err)) begin
                        d.best_err = tscl_err;
                        d.found    = 1'b1;
                        d.best     = {4'(q.presc), 4'd0, 4'(q.scldel), 4'(q.sdadel),
                                      8'(q.sclh), 8'(q.scll)};
                    end
                    if (q.sclh == CNT_LAST) begin
                        adv_scll = 1'b1;
                    end else begin
                        d.sclh  = q.sclh + 1'b1;
                        d.thigh = q.thigh + q.tp;
                    end
                end
            end
            S_FINISH: begin
                d.word = q.found ? q.best : 32'd0;
                d.err  = ~q.found;
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase

        if (adv_presc) begin
            if (q.presc == PRESC_LAST) begin
                d.idx      = '0;
                d.best_err = target;
                d.st       = S_LOAD;
            end else begin
                d.presc  = q.presc + 1'b1;
                d.tp     = q.tp + t_w;
                d.acc    = q.tp + t_w;
                d.scldel = '0;
                d.st     = S_SCL;
            end
        end
        if (adv_scll) begin
            if (q.scll == CNT_LAST) begin
                d.idx = q.idx + 1'b1;
                d.st  = S_LOAD;
            end else begin
                d.scll = q.scll + 1'b1;
                d.tlow = q.tlow + q.tp;
                d.st   = S_LOW;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign word_o = q.word;
    assign done_o = q.done;
    assign err_o  = q.err;

    // R7: completion strobe lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: results move only together with done
    p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(word_o) && $stable(err_o)));

    // R6: an error always reports an empty word
    p_err_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (word_o == 32'd0));

    // R2: at most one stored triple per prescaler
    p_table_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= IW'(PRESC_N));

    // R4: the best error never grows while sweeping high counts
    p_best_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_HIGH) |=> (q.best_err <= $past(q.best_err)));

    // R7: a running search keeps its latched inputs
    p_busy_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st != S_IDLE) && (q.st != S_FINISH)) |=>
            ((q.tclk == $past(q.tclk)) && (q.grade == $past(q.grade))));
endmodule

// File: tb/test_i2c_timing_solver.sv
module test_i2c_timing_solver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] tclk_ns_i = '0;
    logic [1:0]  grade_i = '0;
    logic [31:0] word_o;
    logic        done_o;
    logic        err_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2ns clk = ~clk;

    i2c_timing_solver i_i2c_timing_solver (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .tclk_ns_i (tclk_ns_i),
        .grade_i   (grade_i),
        .word_o    (word_o),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    localparam int NV = 10;
    localparam int VEC_T [NV] = '{10, 4, 20, 8, 16, 50, 40, 200, 0, 10};
    localparam int VEC_G [NV] = '{1,  1, 1,  2, 2,  0,  0,  2,   1, 3};

    // exhaustive model built from R1..R6
    function automatic logic [32:0] model(int t, int g);
        longint lmin, hmin, tr, tf, su, vd, pmin, pmax, tgt;
        longint smin, smax, best;
        logic [31:0] w;
        logic ok;
        if (t == 0 || g == 3) return {1'b1, 32'd0};
        case (g)
            0: begin lmin=4700; hmin=4000; tr=640; tf=20;  su=250; vd=3450; pmin=8333; pmax=12500; tgt=10000; end
            1: begin lmin=1300; hmin=600;  tr=250; tf=100; su=100; vd=900;  pmin=2083; pmax=3125;  tgt=2500;  end
            default: begin lmin=500; hmin=260; tr=60; tf=100; su=50; vd=450; pmin=833; pmax=1250; tgt=1000; end
        endcase
        smin = tf - 50 - 3*t;       if (smin < 0) smin = 0;
        smax = vd - tr - 260 - 4*t; if (smax < 0) smax = 0;
        best = tgt; w = 0; ok = 0;
        for (int p = 0; p < 16; p++) begin
            longint tp;
            int sc, sd;
            tp = (p + 1) * t; sc = -1; sd = -1;
            for (int s = 0; s < 16; s++)
                if (sc < 0 && (s + 1) * tp >= tr + su) sc = s;
            for (int s = 0; s < 16; s++)
                if (sd < 0 && s * tp >= smin && s * tp <= smax) sd = s;
            if (sc >= 0 && sd >= 0) begin
                for (int l = 0; l < 256; l++) begin
                    longint tl;
                    tl = 50 + 2*t + (l + 1) * tp;
                    if (tl > lmin && t < (tl - 50) / 4) begin
                        for (int h = 0; h < 256; h++) begin
                            longint th, ts, e;
                            th = 50 + 2*t + (h + 1) * tp;
                            ts = tl + th + tr + tf;
                            if (ts >= pmin && ts <= pmax && th >= hmin && t < th) begin
                                e = (ts > tgt) ? ts - tgt : tgt - ts;
                                if (e < best) begin
                                    best = e; ok = 1;
                                    w = {4'(p), 4'd0, 4'(sc), 4'(sd), 8'(h), 8'(l)};
                                end
                            end
                        end
                    end
                end
            end
        end
        return {~ok, ok ? w : 32'd0};
    endfunction

    task automatic check(bit cond, string req, string what, logic [32:0] act, logic [32:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(int t, int g);
        @(negedge clk);
        tclk_ns_i = 16'(t); grade_i = 2'(g); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        int n;
        n = 0; seen = 0;
        while (!done_o && n < 60000) begin @(negedge clk); n++; end
        seen = done_o;
        check(seen, "R7", "done seen", {32'd0, seen}, 33'd1);
    endtask

    task automatic run_vec(int t, int g);
        logic [32:0] exp;
        logic [31:0] w;
        bit seen;
        exp = model(t, g);
        pulse_start(t, g);
        wait_done(seen);
        if (seen) begin
            check({err_o, word_o} == exp, "R1 R2 R3 R4 R5 R6", "word", {err_o, word_o}, exp);
            w = word_o;
            @(negedge clk);
            check(!done_o, "R7", "single pulse", {32'd0, done_o}, 33'd0);
            repeat (3) @(negedge clk);
            check(word_o == w, "R8", "word held", {1'b0, word_o}, {1'b0, w});
        end
    endtask

    initial begin
        logic [32:0] exp;
        bit seen;
        int extra;
        repeat (3) @(negedge clk);
        check({done_o, err_o, word_o} == 34'd0, "R8", "reset state",
              {err_o, word_o}, 33'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VEC_T[i], VEC_G[i]);

        // R7: second start while busy must not alter the result
        exp = model(10, 1);
        pulse_start(10, 1);
        repeat (4) @(negedge clk);
        pulse_start(200, 2);
        wait_done(seen);
        if (seen) check({err_o, word_o} == exp, "R7", "busy start ignored",
                        {err_o, word_o}, exp);
        extra = 0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check(extra == 0, "R7", "no second done", 33'(extra), 33'd0);

        // R6: error result then valid result clears the flag
        run_vec(200, 2);
        run_vec(8, 2);
        check(!err_o, "R6", "error cleared", {32'd0, err_o}, 33'd0);

        ended = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4ns * 190000);
        if (!ended) begin
            checks++; fails++;
            $display("FAIL R7 watchdog: actual timeout expected done");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule